// File: doc/BRIEF.md
# MESI snooping line controller with transient bus states

This block keeps coherence for a single-level write-back cache that sits on an atomic shared bus. It serves one processor access at a time. Reads that hit in S, E or M, and writes that hit in E or M, complete locally. A read miss, a write miss or a write to a shared line raises a bus request. While the request waits for the grant, the controller holds a transient state that remembers which command it will issue. On the grant it drives BusRd, BusRdX or BusUpgr for one cycle, and the line's new state is installed in that same cycle.

Snooped traffic is served in every cycle, including the cycles spent waiting for the grant. A dirty line flushes when another master reads or claims it. A clean line reports that it is shared and, when claimed, drops to I. If a pending upgrade loses its shared copy to a snooped claim, the pending command turns into BusRdX. A miss that displaces a dirty line sends a write-back of that line on the bus cycle just before its own command. The tag store is a small direct-mapped register file: the low address bits select the line and the remaining bits are the tag.

Top module: `mesiSnoopLine`

## Requirements
- R1: A read that misses raises busReq. After a one-cycle busGrant, the next cycle carries busCmd 1 (BusRd) with the request address. The line settles in S if busShared is high in that cycle and in E if it is low. A later write to a line in S needs the bus, while a write to a line in E does not.
- R2: A write to a line in S raises busReq and then issues busCmd 3 (BusUpgr). The line is then in M, so the next snooped BusRd of it gets snpFlush.
- R3: A write that misses issues busCmd 2 (BusRdX) after the grant, and the line ends in M.
- R4: If a snooped BusRdX (snpCmd 2) hits the line of a pending upgrade while the controller waits for the grant, the snoop sees snpShared and the local copy is invalidated. The command then issued is BusRdX and not BusUpgr.
- R5: A snooped BusRd that hits a line in M asserts snpFlush and leaves the line in S. A snooped BusRdX that hits a line in M asserts snpFlush and leaves the line in I.
- R6: A read that hits in S, E or M, and a write that hits in E or M, raise no busReq. For these, done is high in the cycle after acceptance. A write to a line in E leaves it in M.
- R7: A snoop that hits a line in S or E asserts snpShared and not snpFlush. BusRd moves E to S. BusRdX and BusUpgr (snpCmd 3) invalidate the line.
- R8: While busReq waits for the grant, snoops on other lines are still answered, and a dirty line still flushes. A dirty victim that is flushed and invalidated in this way is then not written back.
- R9: For a bus access, done stays low until the cycle after the command cycle, so write data never enters a line that is still shared.
- R10: When the line being replaced is in M with another tag, busCmd 0 (write-back) with the victim address is driven on the cycle right after the grant, and the miss command follows on the next cycle. busCmdValid is high only while busReq is high.
- R11: In a cycle with snpValid high, reqReady is low and no request is accepted. The snoop updates the line first, and the held request is then judged against the updated state.
- R12: After reset every line is I, reqReady is high, busReq, busCmdValid and done are low, and snoops get neither snpShared nor snpFlush. The line index is reqAddr[1:0] and the tag is the upper bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Processor request valid |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | ADDR_W | Block address of the request |
| reqReady | output | 1 | Request can be accepted this cycle |
| done | output | 1 | One-cycle pulse when the access commits |
| busReq | output | 1 | Bus request, held until the command cycle ends |
| busGrant | input | 1 | One-cycle bus grant |
| busCmdValid | output | 1 | A command is driven on the bus this cycle |
| busCmd | output | 2 | 0 write-back, 1 BusRd, 2 BusRdX, 3 BusUpgr |
| busAddr | output | ADDR_W | Address of the driven command |
| busShared | input | 1 | Wired-OR shared response, sampled in the command cycle |
| snpValid | input | 1 | A snooped transaction from another master is present |
| snpCmd | input | 2 | Snooped command, same encoding as busCmd |
| snpAddr | input | ADDR_W | Snooped address |
| snpShared | output | 1 | Local clean copy present (S or E) |
| snpFlush | output | 1 | Local dirty copy present, data is flushed |

## Verification
Two kinds of event can fall in the same cycle. The first is a processor request arriving together with a snoop on the same line. The bench drives a write to a line in E and a snooped BusRd of that line in the same cycle. It expects the request to be held off, the snoop to see the clean copy, and the held write to go to the bus as an upgrade. The second is a snoop that lands while the controller waits for its grant. The bench places snooped claims between the request and the grant. It checks that the pending upgrade is issued as BusRdX, and that a dirty victim flushed by a snoop is not written back.

// File: rtl/mesiSnoopPkg.sv
package mesiSnoopPkg;
  typedef enum logic [1:0] {LN_I = 2'd0, LN_S = 2'd1, LN_E = 2'd2, LN_M = 2'd3} lineState_t;
  typedef enum logic [1:0] {BC_WB = 2'd0, BC_RD = 2'd1, BC_RDX = 2'd2, BC_UPGR = 2'd3} busCmd_t;
  typedef enum logic [1:0] {CS_IDLE, CS_WAIT, CS_WB, CS_ISSUE} ctlState_t;

  // control -> datapath strobes
  typedef struct packed {
    logic accept;
    logic drvWb;
    logic issue;
  } ctlStrobe_t;

  // datapath -> control status
  typedef struct packed {
    logic needBus;
    logic victimDirty;
  } dpStatus_t;
endpackage

// File: rtl/mesiLineDatapath.sv
module mesiLineDatapath
  import mesiSnoopPkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LINES  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        strobe,
  output dpStatus_t         status,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              snpValid,
  input  logic [1:0]        snpCmd,
  input  logic [ADDR_W-1:0] snpAddr,
  output logic              snpShared,
  output logic              snpFlush,
  input  logic              busShared,
  output logic              busCmdValid,
  output logic [1:0]        busCmd,
  output logic [ADDR_W-1:0] busAddr
);
  localparam int IDX_W = (LINES > 1) ? $clog2(LINES) : 1;
  localparam int TAG_W = ADDR_W - IDX_W;

  logic [TAG_W-1:0] tagMem [LINES];
  lineState_t       stMem  [LINES];

  logic [ADDR_W-1:0] pAddr;
  logic              pWrite;
  busCmd_t           pendCmd;

  logic [IDX_W-1:0] rIdx, sIdx, pIdx;
  logic [TAG_W-1:0] rTag, sTag, pTag;
  logic             rHit, sHit, sKill;
  lineState_t       rSt, sSt, sNext;

  assign rIdx = reqAddr[IDX_W-1:0];
  assign rTag = reqAddr[ADDR_W-1:IDX_W];
  assign sIdx = snpAddr[IDX_W-1:0];
  assign sTag = snpAddr[ADDR_W-1:IDX_W];
  assign pIdx = pAddr[IDX_W-1:0];
  assign pTag = pAddr[ADDR_W-1:IDX_W];

  // processor-side lookup
  assign rHit = (stMem[rIdx] != LN_I) && (tagMem[rIdx] == rTag);
  assign rSt  = rHit ? stMem[rIdx] : LN_I;

  always_comb begin
    status.needBus     = !rHit || (reqWrite && rSt == LN_S);
    status.victimDirty = (stMem[pIdx] == LN_M) && (tagMem[pIdx] != pTag);
  end

  // bus-side lookup and response
  assign sHit = (stMem[sIdx] != LN_I) && (tagMem[sIdx] == sTag);
  assign sSt  = sHit ? stMem[sIdx] : LN_I;

  always_comb begin
    sNext = sSt;
    case (busCmd_t'(snpCmd))
      BC_RD:            if (sSt != LN_I) sNext = LN_S;
      BC_RDX, BC_UPGR:  sNext = LN_I;
      default:          sNext = sSt;
    endcase
  end

  assign snpShared = snpValid && sHit && (sSt == LN_S || sSt == LN_E);
  assign snpFlush  = snpValid && sHit && (sSt == LN_M);
  assign sKill     = snpValid && sHit &&
                     (busCmd_t'(snpCmd) == BC_RDX || busCmd_t'(snpCmd) == BC_UPGR);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < LINES; i++) begin
        stMem[i]  <= LN_I;
        tagMem[i] <= '0;
      end
      pAddr   <= '0;
      pWrite  <= 1'b0;
      pendCmd <= BC_RD;
    end else begin
      if (snpValid && sHit) stMem[sIdx] <= sNext;
      // transient S->M loses its copy: the upgrade becomes a full claim
      if (sKill && pendCmd == BC_UPGR && pAddr == snpAddr) pendCmd <= BC_RDX;
      if (strobe.accept) begin
        pAddr   <= reqAddr;
        pWrite  <= reqWrite;
        pendCmd <= !rHit ? (reqWrite ? BC_RDX : BC_RD) : BC_UPGR;
        if (rHit && reqWrite && rSt != LN_S) stMem[rIdx] <= LN_M;
      end
      if (strobe.issue) begin
        tagMem[pIdx] <= pTag;
        stMem[pIdx]  <= pWrite ? LN_M : (busShared ? LN_S : LN_E);
      end
    end
  end

  assign busCmdValid = strobe.drvWb | strobe.issue;
  assign busCmd      = strobe.drvWb ? BC_WB : pendCmd;
  assign busAddr     = strobe.drvWb ? {tagMem[pIdx], pIdx} : pAddr;

  // R4
  upgr_from_shared_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busCmdValid && busCmd == BC_UPGR) |-> (stMem[pIdx] == LN_S));

  // R5
  flush_leaves_m_chk: assert property (@(posedge clk) disable iff (!rstN)
    snpFlush |=> (stMem[$past(sIdx)] != LN_M));

  // R9
  no_early_dirty_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.accept && status.needBus && reqWrite && rHit) |=> (stMem[$past(rIdx)] != LN_M));
endmodule

// File: rtl/mesiLineControl.sv
module mesiLineControl
  import mesiSnoopPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  output logic       reqReady,
  output logic       done,
  output logic       busReq,
  input  logic       busGrant,
  input  logic       snpValid,
  input  dpStatus_t  status,
  output ctlStrobe_t strobe
);
  ctlState_t state, nxt;
  logic      accept;

  // a snoop owns the line state for its cycle
  assign reqReady = (state == CS_IDLE) && !snpValid;
  assign accept   = reqValid && reqReady;
  assign busReq   = (state != CS_IDLE);

  always_comb begin
    strobe.accept = accept;
    strobe.drvWb  = (state == CS_WB);
    strobe.issue  = (state == CS_ISSUE);
  end

  always_comb begin
    nxt = state;
    case (state)
      CS_IDLE:  if (accept && status.needBus) nxt = CS_WAIT;
      CS_WAIT:  if (busGrant) nxt = status.victimDirty ? CS_WB : CS_ISSUE;
      CS_WB:    nxt = CS_ISSUE;
      default:  nxt = CS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= CS_IDLE;
      done  <= 1'b0;
    end else begin
      state <= nxt;
      done  <= (accept && !status.needBus) || (state == CS_ISSUE);
    end
  end

  // R11
  snoop_holds_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == CS_IDLE && snpValid && reqValid) |=> (!done && !busReq));

  // R9
  no_done_on_request_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busReq) |-> !done);
endmodule

// File: rtl/mesiSnoopLine.sv
module mesiSnoopLine
  import mesiSnoopPkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LINES  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  output logic              reqReady,
  output logic              done,
  output logic              busReq,
  input  logic              busGrant,
  output logic              busCmdValid,
  output logic [1:0]        busCmd,
  output logic [ADDR_W-1:0] busAddr,
  input  logic              busShared,
  input  logic              snpValid,
  input  logic [1:0]        snpCmd,
  input  logic [ADDR_W-1:0] snpAddr,
  output logic              snpShared,
  output logic              snpFlush
);
  ctlStrobe_t strobe;
  dpStatus_t  status;

  mesiLineControl u_ctl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .done(done), .busReq(busReq), .busGrant(busGrant), .snpValid(snpValid),
    .status(status), .strobe(strobe)
  );

  mesiLineDatapath #(.ADDR_W(ADDR_W), .LINES(LINES)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .status(status),
    .reqWrite(reqWrite), .reqAddr(reqAddr),
    .snpValid(snpValid), .snpCmd(snpCmd), .snpAddr(snpAddr),
    .snpShared(snpShared), .snpFlush(snpFlush), .busShared(busShared),
    .busCmdValid(busCmdValid), .busCmd(busCmd), .busAddr(busAddr)
  );

  // R10
  cmd_needs_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    busCmdValid |-> busReq);

  // R1
  grant_to_cmd_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busReq && !busCmdValid && busGrant) |=> busCmdValid);
endmodule

// File: tb/mesiSnoopLine_tb.sv
`timescale 1ns/1ps
module mesiSnoopLine_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       reqValid = 1'b0, reqWrite = 1'b0;
  logic [7:0] reqAddr = '0;
  logic       reqReady, done, busReq, busCmdValid, snpShared, snpFlush;
  logic       busGrant = 1'b0, busShared = 1'b0;
  logic [1:0] busCmd;
  logic [7:0] busAddr;
  logic       snpValid = 1'b0;
  logic [1:0] snpCmd = '0;
  logic [7:0] snpAddr = '0;

  int checks = 0;
  int failures = 0;
  logic [9:0] expQ[$];
  string      tagQ[$];

  localparam logic [1:0] WB = 2'd0, RD = 2'd1, RDX = 2'd2, UPGR = 2'd3;

  always #2.5 clk = ~clk;

  mesiSnoopLine #(.ADDR_W(8), .LINES(4)) u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite), .reqAddr(reqAddr),
    .reqReady(reqReady), .done(done), .busReq(busReq), .busGrant(busGrant),
    .busCmdValid(busCmdValid), .busCmd(busCmd), .busAddr(busAddr), .busShared(busShared),
    .snpValid(snpValid), .snpCmd(snpCmd), .snpAddr(snpAddr),
    .snpShared(snpShared), .snpFlush(snpFlush)
  );

  task automatic chk(input string r, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", r, act, exp);
    end
  endtask

  task automatic expectBus(input logic [1:0] c, input logic [7:0] a, input string r);
    expQ.push_back({c, a});
    tagQ.push_back(r);
  endtask

  // monitor: scoreboard of bus commands
  always @(negedge clk) begin
    if (rstN && busCmdValid) begin
      if (expQ.size() == 0) begin
        checks++; failures++;
        $display("FAIL R10 unexpected bus command actual=%0d expected=none", {busCmd, busAddr});
      end else begin
        logic [9:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        chk(t, int'({busCmd, busAddr}), int'(e));
      end
    end
  end

  task automatic req(input logic w, input logic [7:0] a, input logic bus, input string r);
    @(negedge clk);
    reqWrite = w; reqAddr = a; reqValid = 1'b1;
    #1 chk(r, reqReady, 1);
    @(negedge clk);
    reqValid = 1'b0;
    chk(r, done, bus ? 0 : 1);
    chk(r, busReq, bus ? 1 : 0);
  endtask

  task automatic snoop(input logic [1:0] c, input logic [7:0] a, input logic sh, input logic fl, input string r);
    @(negedge clk);
    snpValid = 1'b1; snpCmd = c; snpAddr = a;
    #1;
    chk(r, snpShared, sh);
    chk(r, snpFlush, fl);
    @(negedge clk);
    snpValid = 1'b0;
  endtask

  task automatic grant();
    @(negedge clk);
    busGrant = 1'b1;
    @(negedge clk);
    busGrant = 1'b0;
  endtask

  task automatic waitDone(input int n, input string r);
    for (int i = 0; i < n; i++) begin
      chk(r, done, 0);
      @(negedge clk);
    end
    chk(r, done, 1);
    chk(r, busReq, 0);
  endtask

  initial begin
    #500000;
    checks++; failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R12 reset state
    chk("R12", reqReady, 1);
    chk("R12", busReq, 0);
    chk("R12", busCmdValid, 0);
    chk("R12", done, 0);
    snoop(RD, 8'h10, 0, 0, "R12");

    // R1 read miss, shared low -> E
    busShared = 1'b0;
    req(0, 8'h10, 1, "R1");
    expectBus(RD, 8'h10, "R1");
    grant();
    waitDone(1, "R1");
    // R6 write in E is silent, read in M hits
    req(1, 8'h10, 0, "R6");
    req(0, 8'h10, 0, "R6");
    // R5 BusRd on M: flush, then S
    snoop(RD, 8'h10, 0, 1, "R5");
    snoop(RD, 8'h10, 1, 0, "R5");
    // R2 write in S: upgrade, done only after command (R9)
    req(1, 8'h10, 1, "R2");
    expectBus(UPGR, 8'h10, "R2");
    grant();
    waitDone(1, "R9");
    snoop(RDX, 8'h10, 0, 1, "R2");
    // R5 BusRdX on M left the line in I
    snoop(RD, 8'h10, 0, 0, "R5");

    // R1 read miss with shared high -> S, then R4
    busShared = 1'b1;
    req(0, 8'h21, 1, "R1");
    expectBus(RD, 8'h21, "R1");
    grant();
    waitDone(1, "R1");
    req(0, 8'h21, 0, "R6");
    req(1, 8'h21, 1, "R1");
    snoop(RDX, 8'h21, 1, 0, "R4");
    expectBus(RDX, 8'h21, "R4");
    grant();
    waitDone(1, "R4");
    snoop(RD, 8'h21, 0, 1, "R4");
    busShared = 1'b0;

    // R3 write miss
    req(1, 8'h32, 1, "R3");
    expectBus(RDX, 8'h32, "R3");
    grant();
    waitDone(1, "R3");
    snoop(RD, 8'h32, 0, 1, "R3");

    // R10 dirty victim write-back, R8 snoop served while waiting
    req(1, 8'h13, 1, "R3");
    expectBus(RDX, 8'h13, "R3");
    grant();
    waitDone(1, "R3");
    req(0, 8'h23, 1, "R10");
    snoop(RD, 8'h32, 1, 0, "R8");
    expectBus(WB, 8'h13, "R10");
    expectBus(RD, 8'h23, "R10");
    grant();
    waitDone(2, "R10");
    snoop(RD, 8'h13, 0, 0, "R10");
    req(0, 8'h23, 0, "R6");
    req(1, 8'h23, 0, "R6");

    // R8 dirty victim flushed during wait: no write-back
    req(0, 8'h33, 1, "R8");
    snoop(RDX, 8'h23, 0, 1, "R8");
    expectBus(RD, 8'h33, "R8");
    grant();
    waitDone(1, "R8");

    // R11 snoop and request in the same cycle on a line in E
    @(negedge clk);
    reqValid = 1'b1; reqWrite = 1'b1; reqAddr = 8'h33;
    snpValid = 1'b1; snpCmd = RD; snpAddr = 8'h33;
    #1;
    chk("R11", reqReady, 0);
    chk("R11", snpShared, 1);
    @(negedge clk);
    snpValid = 1'b0;
    chk("R11", done, 0);
    chk("R11", busReq, 0);
    #1 chk("R11", reqReady, 1);
    @(negedge clk);
    reqValid = 1'b0;
    chk("R11", busReq, 1);
    chk("R11", done, 0);
    expectBus(UPGR, 8'h33, "R11");
    grant();
    waitDone(1, "R11");

    // R7 BusUpgr snoop invalidates a shared line
    snoop(UPGR, 8'h21, 1, 0, "R7");
    snoop(RD, 8'h21, 0, 0, "R7");
    // R7 E goes to S on a snooped read
    req(0, 8'h02, 1, "R7");
    expectBus(RD, 8'h02, "R7");
    grant();
    waitDone(1, "R7");
    snoop(RD, 8'h02, 1, 0, "R7");
    req(1, 8'h02, 1, "R7");
    expectBus(UPGR, 8'h02, "R7");
    grant();
    waitDone(1, "R7");

    repeat (2) @(negedge clk);
    chk("R10", expQ.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule